// File: doc/BRIEF.md
# One-Time-Programmable Byte Write Controller

This block sequences byte-wide programming of a write-once memory whose cells can only be cleared from 1 to 0. A master sends a bit stream through write slots and collects answers through read slots. The stream holds a program command, a start address and a data byte. The block answers with a CRC-16 that the master uses to check what was received. It then waits for a digital indication that the programming pulse has been applied. On that indication it merges the data into the addressed cell by a bitwise AND, unless the page holding that cell is write-protected. Finally it returns the stored byte so the master can verify it.

When verification succeeds, the block steps to the next address. It seeds its CRC generator with that new address and accepts another data byte at once, with no new command. This lets a master stream consecutive bytes until it issues a line reset. When verification fails, the block stops answering until the next line reset.

The array is a register file that starts at all ones. Each 32-byte page has an active-low protect bit, supplied as an input vector.

Top module: `otp_byte_writer`

## Requirements
- R1: After `rst` or a `line_rst` cycle the block waits for a command byte, and every read slot answers 1. Each read slot produces exactly one `rd_valid` pulse, in the cycle after `rd_slot`, with the answer bit on `rd_bit`.
- R2: Bytes arrive least significant bit first, one bit per `wr_slot` cycle. The first byte must be 0x0F. It is followed by the address low byte, the address high byte and one data byte. Any other first byte sends the block to a stalled state.
- R3: Only 11 address bits are kept. Bits 7..3 of the received high byte are forced to 0, both in the address and in the byte fed to the CRC.
- R4: After the data byte, the next 16 read slots return the CRC least significant bit first. The CRC uses polynomial x16+x15+x2+1 in reflected form (0xA001), starts from 0 and is not inverted. It covers the command, the address low byte, the masked high byte and the data byte.
- R5: A `prog_pulse` cycle acts only after the 16th CRC bit has been read and before verification starts. At any other time it is ignored and leaves the array unchanged.
- R6: On an accepted pulse the cell becomes old AND data; unprogrammed cells hold 0xFF. The next 8 read slots return the resulting stored byte, least significant bit first.
- R7: If the page of the address (address bits 10..5) has its `wp_n` bit at 0, the cell is not changed. Verification then returns the unchanged stored byte.
- R8: Verification succeeds when the stored byte has no 1 where the data byte has a 0. On success the address increments, wrapping from 0x7FF to 0x000. The CRC is seeded with the new address, zero-extended to 16 bits. The next data byte is accepted without a command, and its CRC is computed from that seed.
- R9: A failed verification or a rejected command stalls the block. While stalled, read slots answer 1 and write slots and pulses are ignored until `line_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_rst | input | 1 | Bus reset from the master; aborts the transaction |
| wr_slot | input | 1 | Master write slot, one bit per cycle |
| wr_bit | input | 1 | Bit value of the write slot |
| rd_slot | input | 1 | Master read slot request |
| prog_pulse | input | 1 | Programming-pulse event indication |
| wp_n | input | 64 | Per-page protect bits, 0 = page protected |
| rd_bit | output | 1 | Answer bit of the last read slot |
| rd_valid | output | 1 | Pulses one cycle after each read slot |

## Verification
The assertions assume a well-behaved master. It issues at most one of `wr_slot`, `rd_slot` and `prog_pulse` per cycle. It never starts a new write slot in the cycle a byte completes on the step into CRC transmission. It keeps `wp_n` stable while a byte is being programmed. The stimulus honours this by driving one slot per cycle from tasks that follow the protocol order. The only exceptions are pulses deliberately placed mid-CRC or while idle, which check that such pulses are ignored. The protect vector changes only between transactions.

// File: rtl/otp_wr_pkg.sv
package otp_wr_pkg;

  localparam logic [7:0]  CMD_PROG   = 8'h0F;
  localparam logic [15:0] CRC_POLY_R = 16'hA001;

  typedef enum logic [2:0] {
    S_CMD,
    S_ADL,
    S_ADH,
    S_DATA,
    S_CRC,
    S_WAIT,
    S_VFY,
    S_HOLD
  } wr_state_e;

  // reflected CRC-16 update, one byte, LSB first
  function automatic logic [15:0] crc16_byte(input logic [15:0] c_in, input logic [7:0] b);
    logic [15:0] c;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ b[i]) c = (c >> 1) ^ CRC_POLY_R;
      else             c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/otp_bit_rx.sv
module otp_bit_rx (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       slot_en,
  input  logic       bit_in,
  output logic [7:0] byte_q,
  output logic       done
);

  logic [2:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q  <= '0;
      done   <= 1'b0;
      byte_q <= 8'hFF;
    end else begin
      done <= 1'b0;
      if (slot_en) begin
        byte_q <= {bit_in, byte_q[7:1]};
        cnt_q  <= cnt_q + 3'd1;
        if (cnt_q == 3'd7) done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/otp_crc16.sv
module otp_crc16
  import otp_wr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        seed_en,
  input  logic [15:0] seed,
  input  logic        upd_en,
  input  logic [7:0]  upd_byte,
  output logic [15:0] crc_q,
  output logic [15:0] crc_nxt
);

  always_comb crc_nxt = crc16_byte(crc_q, upd_byte);

  always_ff @(posedge clk) begin
    if (rst || clr)   crc_q <= '0;
    else if (seed_en) crc_q <= seed;
    else if (upd_en)  crc_q <= crc_nxt;
  end

endmodule

// File: rtl/otp_wr_array.sv
module otp_wr_array #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            rd_en,
  input  logic [ADDR_W-1:0]               rd_addr,
  output logic [7:0]                      rd_q,
  output logic                            prot,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [7:0]                      wr_data,
  input  logic [(1<<(ADDR_W-PAGE_W))-1:0] wp_n
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  // erased state of the cells: all ones (power-on content, not touched by reset)
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_addr];
  end

  always_comb prot = !wp_n[rd_addr[ADDR_W-1:PAGE_W]];

  // R7
  wp_block_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> wp_n[wr_addr[ADDR_W-1:PAGE_W]]);

  // R6
  only_clear_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ((wr_data & ~rd_q) == 8'h00));

endmodule

// File: rtl/otp_wr_fsm.sv
module otp_wr_fsm
  import otp_wr_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_rst,
  input  logic              wr_slot,
  input  logic              rd_slot,
  input  logic              prog_pulse,
  input  logic [7:0]        rx_byte,
  input  logic              rx_done,
  output logic              rx_en,
  input  logic [15:0]       crc_q,
  input  logic [15:0]       crc_nxt,
  output logic              crc_seed_en,
  output logic [15:0]       crc_seed,
  output logic              crc_upd_en,
  output logic [7:0]        crc_byte,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_q,
  input  logic              prot,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  output logic              rd_bit,
  output logic              rd_valid
);

  localparam int         AH_W    = ADDR_W - 8;
  localparam logic [7:0] HI_MASK = 8'((16'd1 << AH_W) - 16'd1);

  wr_state_e         st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_inc;
  logic [7:0]        data_q;
  logic [7:0]        vbyte_q;
  logic [7:0]        merged;
  logic [15:0]       txsr_q;
  logic [3:0]        txcnt_q;
  logic              vfy_ok;
  logic              vfy_last;
  logic              receiving;

  always_comb begin
    receiving   = (st_q == S_CMD) || (st_q == S_ADL) || (st_q == S_ADH) || (st_q == S_DATA);
    rx_en       = wr_slot && !line_rst && receiving;
    crc_upd_en  = rx_done && !line_rst && receiving;
    crc_byte    = (st_q == S_ADH) ? (rx_byte & HI_MASK) : rx_byte;
    addr_inc    = addr_q + 1'b1;
    vfy_ok      = ((vbyte_q & ~data_q) == 8'h00);
    vfy_last    = (st_q == S_VFY) && rd_slot && (txcnt_q == 4'd7) && !line_rst;
    crc_seed_en = vfy_last && vfy_ok;
    crc_seed    = 16'(addr_inc);
    mem_addr    = addr_q;
    mem_rd_en   = rx_done && !line_rst && (st_q == S_DATA);
    merged      = prot ? mem_q : (mem_q & data_q);
    mem_we      = (st_q == S_WAIT) && prog_pulse && !prot && !line_rst;
    mem_wdata   = mem_q & data_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_CMD;
      addr_q   <= '0;
      data_q   <= 8'hFF;
      vbyte_q  <= 8'hFF;
      txsr_q   <= 16'hFFFF;
      txcnt_q  <= '0;
      rd_bit   <= 1'b1;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_slot;
      if (line_rst) begin
        st_q    <= S_CMD;
        txcnt_q <= '0;
        if (rd_slot) rd_bit <= 1'b1;
      end else begin
        if (rd_slot) rd_bit <= 1'b1;
        case (st_q)
          S_CMD: if (rx_done) st_q <= (rx_byte == CMD_PROG) ? S_ADL : S_HOLD;
          S_ADL: if (rx_done) begin
            addr_q[7:0] <= rx_byte;
            st_q        <= S_ADH;
          end
          S_ADH: if (rx_done) begin
            addr_q[ADDR_W-1:8] <= rx_byte[AH_W-1:0];
            st_q               <= S_DATA;
          end
          S_DATA: if (rx_done) begin
            data_q  <= rx_byte;
            txsr_q  <= crc_nxt;
            txcnt_q <= '0;
            st_q    <= S_CRC;
          end
          S_CRC: if (rd_slot) begin
            rd_bit  <= txsr_q[0];
            txsr_q  <= {1'b1, txsr_q[15:1]};
            txcnt_q <= txcnt_q + 4'd1;
            if (txcnt_q == 4'd15) st_q <= S_WAIT;
          end
          S_WAIT: if (prog_pulse) begin
            vbyte_q <= merged;
            txsr_q  <= {8'hFF, merged};
            txcnt_q <= '0;
            st_q    <= S_VFY;
          end
          S_VFY: if (rd_slot) begin
            rd_bit  <= txsr_q[0];
            txsr_q  <= {1'b1, txsr_q[15:1]};
            txcnt_q <= txcnt_q + 4'd1;
            if (txcnt_q == 4'd7) begin
              if (vfy_ok) begin
                addr_q <= addr_inc;
                st_q   <= S_DATA;
              end else begin
                st_q   <= S_HOLD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R8
  seed_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_DATA && $past(st_q) == S_VFY) |-> (crc_q == 16'(addr_q)));

  // R9
  hold_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_HOLD && rd_slot && !line_rst) |=> rd_bit);

  // R5
  pulse_gate_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (st_q == S_VFY && txcnt_q == 4'd0));

endmodule

// File: rtl/otp_byte_writer.sv
module otp_byte_writer #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            line_rst,
  input  logic                            wr_slot,
  input  logic                            wr_bit,
  input  logic                            rd_slot,
  input  logic                            prog_pulse,
  input  logic [(1<<(ADDR_W-PAGE_W))-1:0] wp_n,
  output logic                            rd_bit,
  output logic                            rd_valid
);

  logic [7:0]        rx_byte;
  logic              rx_done;
  logic              rx_en;
  logic [15:0]       crc_q;
  logic [15:0]       crc_nxt;
  logic              crc_seed_en;
  logic [15:0]       crc_seed;
  logic              crc_upd_en;
  logic [7:0]        crc_byte;
  logic              mem_rd_en;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_q;
  logic              prot;
  logic              mem_we;
  logic [7:0]        mem_wdata;

  otp_bit_rx u_rx (
    .clk     (clk),
    .rst     (rst),
    .clr     (line_rst),
    .slot_en (rx_en),
    .bit_in  (wr_bit),
    .byte_q  (rx_byte),
    .done    (rx_done)
  );

  otp_crc16 u_crc (
    .clk      (clk),
    .rst      (rst),
    .clr      (line_rst),
    .seed_en  (crc_seed_en),
    .seed     (crc_seed),
    .upd_en   (crc_upd_en),
    .upd_byte (crc_byte),
    .crc_q    (crc_q),
    .crc_nxt  (crc_nxt)
  );

  otp_wr_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_arr (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (mem_rd_en),
    .rd_addr (mem_addr),
    .rd_q    (mem_q),
    .prot    (prot),
    .wr_en   (mem_we),
    .wr_addr (mem_addr),
    .wr_data (mem_wdata),
    .wp_n    (wp_n)
  );

  otp_wr_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .line_rst    (line_rst),
    .wr_slot     (wr_slot),
    .rd_slot     (rd_slot),
    .prog_pulse  (prog_pulse),
    .rx_byte     (rx_byte),
    .rx_done     (rx_done),
    .rx_en       (rx_en),
    .crc_q       (crc_q),
    .crc_nxt     (crc_nxt),
    .crc_seed_en (crc_seed_en),
    .crc_seed    (crc_seed),
    .crc_upd_en  (crc_upd_en),
    .crc_byte    (crc_byte),
    .mem_rd_en   (mem_rd_en),
    .mem_addr    (mem_addr),
    .mem_q       (mem_q),
    .prot        (prot),
    .mem_we      (mem_we),
    .mem_wdata   (mem_wdata),
    .rd_bit      (rd_bit),
    .rd_valid    (rd_valid)
  );

endmodule

// File: tb/otp_byte_writer_tb.sv
`timescale 1ns/1ps
module otp_byte_writer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        line_rst = 1'b0;
  logic        wr_slot = 1'b0;
  logic        wr_bit = 1'b0;
  logic        rd_slot = 1'b0;
  logic        prog_pulse = 1'b0;
  logic [63:0] wp_n = '1;
  logic        rd_bit;
  logic        rd_valid;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    logic [15:0] v;
    int          n;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [7:0] model [2048];
  int         cur;

  always #2 clk = ~clk;

  otp_byte_writer u_dut (
    .clk(clk), .rst(rst), .line_rst(line_rst), .wr_slot(wr_slot), .wr_bit(wr_bit),
    .rd_slot(rd_slot), .prog_pulse(prog_pulse), .wp_n(wp_n),
    .rd_bit(rd_bit), .rd_valid(rd_valid)
  );

  function automatic logic [15:0] ref_crc(input logic [15:0] s, input logic [7:0] b);
    logic [15:0] r;
    logic        fb;
    r = s;
    for (int k = 0; k < 8; k++) begin
      fb = r[0] ^ b[k];
      r  = {1'b0, r[15:1]};
      if (fb) r = r ^ 16'hA001;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: assemble answer bits and compare against scoreboard head
  logic [15:0] acc = '0;
  int          acc_n = 0;
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      acc[acc_n] = rd_bit;
      acc_n++;
      if (sb.size() == 0) begin
        check(1'b0, "R1 unexpected answer bit", 16'(rd_bit), 16'h0);
        acc_n = 0;
      end else if (acc_n == sb[0].n) begin
        logic [15:0] m;
        m = (sb[0].n == 16) ? 16'hFFFF : 16'h00FF;
        check((acc & m) == (sb[0].v & m), sb[0].tag, acc & m, sb[0].v & m);
        void'(sb.pop_front());
        acc   = '0;
        acc_n = 0;
      end
    end
  end

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      wr_slot = 1'b1;
      wr_bit  = b[i];
      @(negedge clk);
    end
    wr_slot = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_n(input logic [15:0] v, input int n, input string tag, input bit mid_pulse);
    exp_t e;
    e.v = v; e.n = n; e.tag = tag;
    sb.push_back(e);
    for (int i = 0; i < n; i++) begin
      rd_slot    = 1'b1;
      prog_pulse = mid_pulse && (i == 8);
      @(negedge clk);
    end
    rd_slot    = 1'b0;
    prog_pulse = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse();
    prog_pulse = 1'b1;
    @(negedge clk);
    prog_pulse = 1'b0;
    @(negedge clk);
  endtask

  task automatic bus_reset();
    line_rst = 1'b1;
    @(negedge clk);
    line_rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic header(input logic [7:0] lo, input logic [7:0] hi, output logic [15:0] c);
    send_byte(8'h0F);
    send_byte(lo);
    send_byte(hi);
    c = ref_crc(ref_crc(ref_crc(16'h0, 8'h0F), lo), hi & 8'h07);
    cur = {hi[2:0], lo};
  endtask

  task automatic byte_phase(input logic [7:0] d, input logic [15:0] c0,
                            input string ctag, input string vtag, output bit ok);
    logic [7:0] st;
    bit         pr;
    send_byte(d);
    read_n(ref_crc(c0, d), 16, ctag, 1'b0);
    pulse();
    pr = !wp_n[cur >> 5];
    st = pr ? model[cur] : (model[cur] & d);
    model[cur] = st;
    read_n({8'h00, st}, 8, vtag, 1'b0);
    ok = ((st & ~d) == 8'h00);
    if (ok) cur = (cur + 1) & 2047;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 16'h0, 16'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] c;
    bit          ok;
    for (int i = 0; i < 2048; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rd_bit == 1'b1 && rd_valid == 1'b0, "R1 reset state", {14'h0, rd_valid, rd_bit}, 16'h1);

    // R1: read slots while waiting for a command answer 1
    read_n(16'h00FF, 8, "R1 idle reads", 1'b0);

    // R2 R4 R6 R8: program two consecutive bytes
    header(8'h10, 8'h00, c);
    byte_phase(8'hA5, c, "R4 crc first byte", "R6 verify A5", ok);
    check(ok, "R8 advance after success", 16'(ok), 16'h1);
    byte_phase(8'h3C, 16'(cur), "R8 seeded crc", "R6 verify 3C", ok);
    bus_reset();

    // R6: AND merge onto an already programmed byte
    header(8'h10, 8'h00, c);
    byte_phase(8'hF0, c, "R4 crc rewrite", "R6 merged A0", ok);
    bus_reset();

    // R7 R9: protected page leaves the cell unchanged, verify fails, stall
    wp_n[2] = 1'b0;
    header(8'h45, 8'h00, c);
    byte_phase(8'h00, c, "R4 crc protected", "R7 unchanged FF", ok);
    read_n(16'h00FF, 8, "R9 stalled reads", 1'b0);
    send_byte(8'h0F);
    pulse();
    read_n(16'h00FF, 8, "R9 stall ignores slots", 1'b0);
    bus_reset();

    // R3 R8: high address bits masked; wrap from 0x7FF to 0x000
    header(8'hFF, 8'hFF, c);
    byte_phase(8'h12, c, "R3 crc masked high", "R3 verify 7FF", ok);
    check(cur == 0, "R8 address wrap", 16'(cur), 16'h0);
    byte_phase(8'h7E, 16'(cur), "R8 crc seed zero", "R8 verify at 000", ok);
    bus_reset();

    // R2: unknown command stalls
    send_byte(8'hAA);
    read_n(16'h00FF, 8, "R2 bad command", 1'b0);
    bus_reset();

    // R5: pulses while idle and during CRC are ignored
    pulse();
    header(8'h00, 8'h01, c);
    send_byte(8'h00);
    read_n(ref_crc(c, 8'h00), 16, "R5 crc with stray pulse", 1'b1);
    bus_reset();
    header(8'h00, 8'h01, c);
    byte_phase(8'hFF, c, "R4 crc reprobe", "R5 cell untouched", ok);
    bus_reset();

    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R1 all answers seen", 16'(sb.size()), 16'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule